// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a synchronous memory with two independent access ports, left and right. Each port has its own chip enable, write strobe, address, write data and registered read data. Both ports can read and write at any time. A collision exists only when both ports are enabled on the same word. Collision logic then picks one port and raises a busy flag on the other, so that the other port's write is held off until the collision clears.

A mode pin selects where the busy decision comes from. In master mode the internal arbiter decides and drives the busy outputs. The port that was settled on the contested word first wins. If both ports arrive in the same cycle, the left port wins. In slave mode an external master supplies one busy input per port. Those inputs gate the writes, and the internal decision is not used. Reads are never stalled. A word written on one port can be read on the other port in the very next cycle.

The arbiter is a three-state machine. ARB_IDLE means no collision. ARB_LEFT_HOLDS means the left port owns the contested word and the right port is busy. ARB_RIGHT_HOLDS is the mirror case. The transitions are named as follows:
- claim_left: ARB_IDLE to ARB_LEFT_HOLDS. It fires on a new match when the left port arrived first, or on a tie.
- claim_right: ARB_IDLE to ARB_RIGHT_HOLDS. It fires on a new match when the right port arrived first.
- keep: a holding state stays put while the match persists.
- release: either holding state returns to ARB_IDLE when the match ends.

Top module: `dpc_ram_top`

## Requirements
- R1: A busy output is asserted only when both chip enables are high and both addresses are equal. Otherwise both busy outputs are low.
- R2: On a new collision, the port whose chip enable and address were already unchanged from the previous cycle wins. Busy is raised only on the other port, in the same cycle as the collision.
- R3: When neither port was settled on the word before (a same-cycle arrival), the left port wins. Only the right busy output goes high, and the two busy outputs are never high together.
- R4: A write presented on a port whose effective busy is high leaves the memory word unchanged.
- R5: Busy is released in the same cycle that the addresses differ or either chip enable drops.
- R6: The winning port keeps priority for as long as the collision lasts. A collision that starts after a release is arbitrated anew.
- R7: When slave_mode is 1, both busy outputs are 0. Each port's write is gated only by that port's busy input (1 = blocked), and the internal arbiter has no effect.
- R8: Reads are never blocked. When a port's chip enable is high at a clock edge, its read data after that edge equals the word held before that edge's writes. When the chip enable is low, the read data holds its value.
- R9: A write performed at a clock edge is returned by a read of the same address on the other port presented in the following cycle.
- R10: A write request that was blocked by busy and is still held completes at the first edge where its busy is low.
- R11: After reset, both busy outputs and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: busy comes from the busy inputs; 0: internal arbiter |
| l_ce | input | 1 | Left chip enable |
| l_wr | input | 1 | Left write strobe (1 = write) |
| l_addr | input | AW | Left word address |
| l_wdata | input | WIDTH | Left write data |
| l_busy_in | input | 1 | Left external busy, used in slave mode |
| l_busy_out | output | 1 | Left busy flag from the arbiter |
| l_rdata | output | WIDTH | Left registered read data |
| r_ce | input | 1 | Right chip enable |
| r_wr | input | 1 | Right write strobe (1 = write) |
| r_addr | input | AW | Right word address |
| r_wdata | input | WIDTH | Right write data |
| r_busy_in | input | 1 | Right external busy, used in slave mode |
| r_busy_out | output | 1 | Right busy flag from the arbiter |
| r_rdata | output | WIDTH | Right registered read data |

## Verification
The hardest situation to reach is a collision where arrival order decides the winner. One port must sit on a word for at least a cycle while the other port moves onto it, either by changing address or by raising its chip enable. The arrival must then be sustained long enough to show that priority is kept, and then released and re-formed to show fresh arbitration. Directed sequences build each of these orders explicitly. They cover a held write that completes on release and the same-cycle tie. The random phase draws addresses from a pool of four words, including the last word, so that collisions, releases and re-arbitration occur hundreds of times. A bench model tracks who arrived first and predicts busy and read data cycle by cycle.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE        = 2'd0,
        ARB_LEFT_HOLDS  = 2'd1,
        ARB_RIGHT_HOLDS = 2'd2
    } arb_state_e;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

endpackage

// File: rtl/dpc_arbiter.sv
`timescale 1ns/1ps
module dpc_arbiter
    import dpc_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce,
    input  logic [AW-1:0] l_addr,
    input  logic          r_ce,
    input  logic [AW-1:0] r_addr,
    output logic          l_lose,
    output logic          r_lose
);

    arb_state_e    state_q;
    arb_state_e    state_d;

    // One-cycle history of each port, used to judge arrival order
    logic          l_ce_q;
    logic          r_ce_q;
    logic [AW-1:0] l_addr_q;
    logic [AW-1:0] r_addr_q;

    logic          match;
    logic          l_settled;
    logic          r_settled;
    logic          right_first;

    assign match       = l_ce && r_ce && (l_addr == r_addr);
    assign l_settled   = l_ce_q && (l_addr_q == l_addr);
    assign r_settled   = r_ce_q && (r_addr_q == r_addr);
    // A tie (both new or both settled) goes to the left port
    assign right_first = r_settled && !l_settled;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Arrival history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_ce_q   <= 1'b0;
            r_ce_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            l_ce_q   <= l_ce;
            r_ce_q   <= r_ce;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    // Next state: claim_left, claim_right, keep, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (match) begin
                    state_d = right_first ? ARB_RIGHT_HOLDS : ARB_LEFT_HOLDS;
                end
            end
            ARB_LEFT_HOLDS,
            ARB_RIGHT_HOLDS: begin
                if (!match) begin
                    state_d = ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // Outputs: the loser is flagged in the very cycle of the collision
    always_comb begin
        l_lose = 1'b0;
        r_lose = 1'b0;
        if (match) begin
            unique case (state_q)
                ARB_IDLE: begin
                    l_lose = right_first;
                    r_lose = !right_first;
                end
                ARB_LEFT_HOLDS:  r_lose = 1'b1;
                ARB_RIGHT_HOLDS: l_lose = 1'b1;
                default: begin
                    l_lose = 1'b0;
                    r_lose = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dpc_port_gate.sv
`timescale 1ns/1ps
module dpc_port_gate (
    input  logic slave_mode,
    input  logic ce,
    input  logic wr,
    input  logic arb_lose,
    input  logic ext_busy,
    output logic wr_en,
    output logic busy_out
);

    logic busy_eff;

    always_comb begin
        busy_eff = slave_mode ? ext_busy : arb_lose;
        wr_en    = ce && wr && !busy_eff;
        busy_out = !slave_mode && arb_lose;
    end

endmodule

// File: rtl/dpc_mem_core.sv
`timescale 1ns/1ps
module dpc_mem_core
    import dpc_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS-1:0]           ce,
    input  logic [NUM_PORTS-1:0]           we,
    input  logic [NUM_PORTS-1:0][AW-1:0]   addr,
    input  logic [NUM_PORTS-1:0][WIDTH-1:0] wdata,
    output logic [NUM_PORTS-1:0][WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Both write ports share one process; left is applied first
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (we[p]) begin
                mem[addr[p]] <= wdata[p];
            end
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g] <= '0;
            end else if (ce[g]) begin
                rdata[g] <= mem[addr[g]];
            end
        end
    end

endmodule

// File: rtl/dpc_ram_top.sv
`timescale 1ns/1ps
module dpc_ram_top
    import dpc_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_mode,
    input  logic             l_ce,
    input  logic             l_wr,
    input  logic [AW-1:0]    l_addr,
    input  logic [WIDTH-1:0] l_wdata,
    input  logic             l_busy_in,
    output logic             l_busy_out,
    output logic [WIDTH-1:0] l_rdata,
    input  logic             r_ce,
    input  logic             r_wr,
    input  logic [AW-1:0]    r_addr,
    input  logic [WIDTH-1:0] r_wdata,
    input  logic             r_busy_in,
    output logic             r_busy_out,
    output logic [WIDTH-1:0] r_rdata
);

    logic [NUM_PORTS-1:0]             ce_v;
    logic [NUM_PORTS-1:0]             wr_v;
    logic [NUM_PORTS-1:0]             lose_v;
    logic [NUM_PORTS-1:0]             ext_v;
    logic [NUM_PORTS-1:0]             we_v;
    logic [NUM_PORTS-1:0]             busy_v;
    logic [NUM_PORTS-1:0][AW-1:0]     addr_v;
    logic [NUM_PORTS-1:0][WIDTH-1:0]  wd_v;
    logic [NUM_PORTS-1:0][WIDTH-1:0]  rd_v;

    assign ce_v   = {r_ce, l_ce};
    assign wr_v   = {r_wr, l_wr};
    assign ext_v  = {r_busy_in, l_busy_in};
    assign addr_v = {r_addr, l_addr};
    assign wd_v   = {r_wdata, l_wdata};

    dpc_arbiter #(.AW(AW)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_ce   (l_ce),
        .l_addr (l_addr),
        .r_ce   (r_ce),
        .r_addr (r_addr),
        .l_lose (lose_v[PORT_L]),
        .r_lose (lose_v[PORT_R])
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_gate
        dpc_port_gate u_gate (
            .slave_mode (slave_mode),
            .ce         (ce_v[g]),
            .wr         (wr_v[g]),
            .arb_lose   (lose_v[g]),
            .ext_busy   (ext_v[g]),
            .wr_en      (we_v[g]),
            .busy_out   (busy_v[g])
        );
    end

    dpc_mem_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce_v),
        .we    (we_v),
        .addr  (addr_v),
        .wdata (wd_v),
        .rdata (rd_v)
    );

    assign l_busy_out = busy_v[PORT_L];
    assign r_busy_out = busy_v[PORT_R];
    assign l_rdata    = rd_v[PORT_L];
    assign r_rdata    = rd_v[PORT_R];

endmodule

// File: rtl/dpc_checker.sv
`timescale 1ns/1ps
module dpc_checker #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slave_mode,
    input logic          l_ce,
    input logic [AW-1:0] l_addr,
    input logic          r_ce,
    input logic [AW-1:0] r_addr,
    input logic          l_busy_out,
    input logic          r_busy_out
);

    logic same;
    assign same = l_ce && r_ce && (l_addr == r_addr);

    // R1 and R5: no busy without a collision
    a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        !same |-> (!l_busy_out && !r_busy_out));

    // R3: never both busy
    a_r3_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy_out && r_busy_out));

    // R2: the port already settled on the word wins a fresh collision
    a_r2_left_settled_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && same && !$past(l_ce && r_ce && (l_addr == r_addr))
         && $past(l_ce) && ($past(l_addr) == l_addr)
         && !($past(r_ce) && ($past(r_addr) == r_addr)))
        |-> (r_busy_out && !l_busy_out));

    a_r2_right_settled_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && same && !$past(l_ce && r_ce && (l_addr == r_addr))
         && $past(r_ce) && ($past(r_addr) == r_addr)
         && !($past(l_ce) && ($past(l_addr) == l_addr)))
        |-> (l_busy_out && !r_busy_out));

    // R6: priority kept while the collision persists
    a_r6_keep_right_busy: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy_out |=> (!(same && !slave_mode) || r_busy_out));

    a_r6_keep_left_busy: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_out |=> (!(same && !slave_mode) || l_busy_out));

    // R7: busy outputs silent in slave mode
    a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (!l_busy_out && !r_busy_out));

endmodule

bind dpc_ram_top dpc_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .l_ce       (l_ce),
    .l_addr     (l_addr),
    .r_ce       (r_ce),
    .r_addr     (r_addr),
    .l_busy_out (l_busy_out),
    .r_busy_out (r_busy_out)
);

// File: tb/dpc_ram_top_tb.sv
`timescale 1ns/1ps
module dpc_ram_top_tb;

    localparam int DEPTH = 1024;
    localparam int WIDTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slave_mode = 1'b0;
    logic             l_ce = 1'b0, l_wr = 1'b0, l_busy_in = 1'b0;
    logic [AW-1:0]    l_addr = '0;
    logic [WIDTH-1:0] l_wdata = '0;
    logic             r_ce = 1'b0, r_wr = 1'b0, r_busy_in = 1'b0;
    logic [AW-1:0]    r_addr = '0;
    logic [WIDTH-1:0] r_wdata = '0;
    logic             l_busy_out, r_busy_out;
    logic [WIDTH-1:0] l_rdata, r_rdata;

    always #5 clk = ~clk;

    dpc_ram_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_ce(l_ce), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_busy_in(l_busy_in), .l_busy_out(l_busy_out), .l_rdata(l_rdata),
        .r_ce(r_ce), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_busy_in(r_busy_in), .r_busy_out(r_busy_out), .r_rdata(r_rdata)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Bench model, built from the requirements
    logic [WIDTH-1:0] sh [DEPTH];
    int               m_owner = 0;   // 0 none, 1 left holds, 2 right holds
    logic             m_lce_p = 1'b0, m_rce_p = 1'b0;
    logic [AW-1:0]    m_la_p = '0, m_ra_p = '0;
    logic [WIDTH-1:0] exp_lrd = '0, exp_rrd = '0;
    string            prev_tag = "R11";

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected busy for a cycle: R1 R2 R3 R5 R6 R7
    function automatic logic [1:0] arb_lose(input logic lce, input logic [AW-1:0] la,
                                            input logic rce, input logic [AW-1:0] ra);
        logic m, ls, rs;
        m  = lce && rce && (la == ra);
        ls = m_lce_p && (m_la_p == la);
        rs = m_rce_p && (m_ra_p == ra);
        if (!m)                  return 2'b00;
        else if (m_owner == 1)   return 2'b10;
        else if (m_owner == 2)   return 2'b01;
        else if (rs && !ls)      return 2'b01;
        else                     return 2'b10;
    endfunction

    task automatic step(input logic lce, lwr, input logic [AW-1:0] la, input logic [WIDTH-1:0] ld,
                        input logic rce, rwr, input logic [AW-1:0] ra, input logic [WIDTH-1:0] rd,
                        input logic slv, bli, bri, input string tag);
        logic [1:0] lose;
        logic       lbe, rbe;
        @(negedge clk);
        // R8: read data from the previous edge
        chk(prev_tag, "R8 l_rdata", 32'(l_rdata), 32'(exp_lrd));
        chk(prev_tag, "R8 r_rdata", 32'(r_rdata), 32'(exp_rrd));
        l_ce = lce; l_wr = lwr; l_addr = la; l_wdata = ld;
        r_ce = rce; r_wr = rwr; r_addr = ra; r_wdata = rd;
        slave_mode = slv; l_busy_in = bli; r_busy_in = bri;
        #1;
        lose = arb_lose(lce, la, rce, ra);
        chk(tag, "l_busy_out", 32'(l_busy_out), 32'(!slv && lose[0]));
        chk(tag, "r_busy_out", 32'(r_busy_out), 32'(!slv && lose[1]));
        lbe = slv ? bli : lose[0];
        rbe = slv ? bri : lose[1];
        if (lce) exp_lrd = sh[la];
        if (rce) exp_rrd = sh[ra];
        // R4 R10: writes land only when not busy
        if (lce && lwr && !lbe) sh[la] = ld;
        if (rce && rwr && !rbe) sh[ra] = rd;
        if (!(lce && rce && la == ra)) m_owner = 0;
        else if (m_owner == 0)         m_owner = lose[1] ? 1 : 2;
        m_lce_p = lce; m_rce_p = rce; m_la_p = la; m_ra_p = ra;
        prev_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(0, 0, '0, '0, 0, 0, '0, '0, 0, 0, 0, tag);
    endtask

    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11", "l_busy_out", 32'(l_busy_out), 0);
        chk("R11", "r_busy_out", 32'(r_busy_out), 0);
        chk("R11", "l_rdata", 32'(l_rdata), 0);
        chk("R11", "r_rdata", 32'(r_rdata), 0);

        // Prefill the words used below
        step(1, 1, 0, 16'h1000, 0, 0, 0, 0, 0, 0, 0, "R9 prefill");
        step(1, 1, 1, 16'h1001, 1, 1, 2, 16'h1002, 0, 0, 0, "R1 distinct");
        step(1, 1, 3, 16'h1003, 1, 1, 5, 16'h1005, 0, 0, 0, "R1 distinct");
        step(1, 1, TOP, 16'h1FFF, 0, 0, 0, 0, 0, 0, 0, "R9 prefill");
        // R9: cross-port read right after a write
        step(0, 0, 0, 0, 1, 1, 4, 16'h4444, 0, 0, 0, "R9 write");
        step(1, 0, 4, 0, 1, 0, TOP, 0, 0, 0, 0, "R9 cross read");
        idle("R9 cross read");

        // R2 by address: left settled on 5, right moves onto 5 and tries a write
        step(1, 0, 5, 0, 1, 0, 3, 0, 0, 0, 0, "R2 setup");
        step(1, 0, 5, 0, 1, 1, 5, 16'hBAD0, 0, 0, 0, "R2 R4 right blocked");
        step(1, 0, 5, 0, 1, 1, 5, 16'hBAD0, 0, 0, 0, "R6 R4 held");
        step(1, 0, 5, 0, 1, 0, 3, 0, 0, 0, 0, "R5 addr release");
        step(0, 0, 0, 0, 1, 0, 5, 0, 0, 0, 0, "R4 readback");
        idle("R4 readback");

        // R2 by chip enable, then R10 held write completes on release
        step(1, 0, 2, 0, 0, 0, 2, 0, 0, 0, 0, "R2 ce setup");
        step(1, 0, 2, 0, 1, 1, 2, 16'hBEEF, 0, 0, 0, "R2 ce arrival");
        step(0, 0, 2, 0, 1, 1, 2, 16'hBEEF, 0, 0, 0, "R5 R10 ce release");
        step(1, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R10 readback");
        idle("R10 readback");

        // Mirror: right settled first, left loses and holds its write
        step(0, 0, 3, 0, 1, 0, 3, 0, 0, 0, 0, "R2 mirror setup");
        step(1, 1, 3, 16'hDEAD, 1, 0, 3, 0, 0, 0, 0, "R2 left blocked");
        step(1, 1, 3, 16'hDEAD, 1, 0, 3, 0, 0, 0, 0, "R6 left held");
        step(1, 1, 3, 16'hDEAD, 0, 0, 3, 0, 0, 0, 0, "R10 left lands");
        step(0, 0, 0, 0, 1, 0, 3, 0, 0, 0, 0, "R10 readback");

        // R3: same-cycle arrival, left wins
        idle("R3 setup");
        step(1, 1, 0, 16'hA0A0, 1, 1, 0, 16'hB0B0, 0, 0, 0, "R3 tie");
        step(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 R8 read during busy");
        // R6: release, then left returns late and loses the fresh round
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R6 release");
        step(1, 1, 0, 16'hC0C0, 1, 0, 0, 0, 0, 0, 0, "R6 fresh round");
        idle("R6 readback");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 readback");

        // R7: slave mode, external busy gates writes
        step(1, 1, 1, 16'hC1C1, 1, 1, 1, 16'hC2C2, 1, 0, 1, "R7 right gated");
        step(1, 1, 1, 16'hC3C3, 1, 1, 1, 16'hC4C4, 1, 1, 1, "R7 both gated");
        step(1, 0, 1, 0, 1, 0, 1, 0, 1, 1, 1, "R7 R8 readback");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R7 exit");
        idle("R7 exit");

        // Random phase with a fixed seed
        begin
            logic [AW-1:0] pool [4];
            int unused_seed;
            pool[0] = 0; pool[1] = 1; pool[2] = 2; pool[3] = TOP;
            unused_seed = $urandom(32'h5EED);
            for (int i = 0; i < 3000; i++) begin
                logic slv;
                slv = (i >= 2000 && i < 2400);
                step(($urandom % 10) < 7, $urandom % 2, pool[$urandom % 4], 16'($urandom),
                     ($urandom % 10) < 7, $urandom % 2, pool[$urandom % 4], 16'($urandom),
                     slv, $urandom % 2, $urandom % 2,
                     "R1 R2 R4 R5 R6 R7 R8 R9 random");
            end
        end
        idle("R8 final");
        idle("R8 final");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule